// File: doc/BRIEF.md
# Chip erase verify sequencer

This block sits on the host side of a byte-wide flash command bus and runs a whole chip-erase flow by itself. After a start pulse it arms the erase and then fires it, each with a command write. It waits a programmable minimum erase pulse. It then checks the array byte by byte. Each check is a verify command write carrying the byte's address, followed by a read of that address. A byte that does not read back as all ones triggers another erase. The check then resumes at that same byte and does not go back to the start of the array.

Every bus transfer is a request held until the bus side shows ready. A read's data comes back later with a valid strobe. When the last address passes, or when the retry limit is used up, the sequencer writes the plain read command so that the device leaves verify mode. It then raises done or fail. On a failure it also reports the byte that could not be erased. A retry counter reports how many extra erases the flow needed.

Top module: `erase_verify_seq`

## Requirements
- R1: After reset the block is idle. busy, bus_wr, bus_rd, done and fail are low, and retry_cnt is 0.
- R2: A start pulse while idle begins the flow with two back-to-back command writes of 20h and no other write between them. A start pulse while busy has no effect on the running flow.
- R3: A write or read request, once raised, stays raised with stable address and data until a rising clock edge samples bus_rdy high. That edge completes the transfer.
- R4: At least pulse_cycles clock cycles pass between the accepted second 20h write and the next accepted write, which is a verify command.
- R5: Each byte check is a write of A0h with bus_addr set to the byte's address, followed by one read of that same address. The read result is taken from bus_rdata in the cycle bus_rvalid is high.
- R6: A read result of FFh passes the byte. Checking moves to the next address, or ends after the highest address (2^ADDR_W − 1).
- R7: Any other read result starts a new erase (two 20h writes and the pulse wait), increments retry_cnt, and repeats the check at the same address. Verify addresses never decrease within a run.
- R8: If a byte fails while retry_cnt equals MAX_RETRY, no further erase is issued. fail is raised and fail_addr holds that byte's address.
- R9: Every run ends with a single write of 00h. On the edge that accepts it, done (on success) or fail is set. These flags are never both high, and they stay set until the next accepted start.
- R10: retry_cnt equals the number of erases issued in the run minus one, and never exceeds MAX_RETRY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a flow when idle |
| pulse_cycles | input | PULSE_W | Minimum erase pulse in clock cycles |
| bus_rdy | input | 1 | Bus side accepts the pending request this edge |
| bus_wr | output | 1 | Command write request |
| bus_rd | output | 1 | Read request |
| bus_addr | output | ADDR_W | Address of the request |
| bus_wdata | output | DATA_W | Command byte of a write request |
| bus_rdata | input | DATA_W | Read data |
| bus_rvalid | input | 1 | bus_rdata is valid this cycle |
| busy | output | 1 | Flow in progress |
| done | output | 1 | Last run erased every byte |
| fail | output | 1 | Last run ran out of retries |
| fail_addr | output | ADDR_W | Byte that could not be erased |
| retry_cnt | output | RETRY_W | Extra erases used in this run |

## Verification
The hardest case to reach is a byte deep in the array that needs more erases than all bytes before it. Only that case shows whether checking resumes at the failing byte or starts over. The bench's device model gives each byte its own count of erases needed before it reads all ones. Need patterns are then swept over a 16-byte array: a slow last byte, a repeating slow stripe, a slow byte exactly at the retry limit and one just past it, and a ramp. The verify and read counts seen on the bus then pin down the resume point. The bench runs the patterns with several pulse lengths against a random ready pattern, and sends a second start in the middle of one run.

// File: rtl/erase_verify_seq.sv
module erase_verify_seq #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int PULSE_W   = 20,
  parameter int RETRY_W   = 10,
  parameter int MAX_RETRY = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PULSE_W-1:0] pulse_cycles,
  input  logic               bus_rdy,
  output logic               bus_wr,
  output logic               bus_rd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  input  logic               bus_rvalid,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [ADDR_W-1:0]  fail_addr,
  output logic [RETRY_W-1:0] retry_cnt
);
  localparam logic [ADDR_W-1:0]  LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0]  ERASED    = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0]  CMD_READ  = DATA_W'(8'h00);
  localparam logic [DATA_W-1:0]  CMD_ERASE = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0]  CMD_VFY   = DATA_W'(8'hA0);
  localparam logic [RETRY_W-1:0] RETRY_TOP = RETRY_W'(MAX_RETRY);

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_FIRE, S_SOAK, S_VCMD, S_RREQ, S_RWAIT, S_EXIT
  } st_t;

  st_t                state;
  logic [ADDR_W-1:0]  addr;
  logic [PULSE_W-1:0] soak;
  logic               bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr      <= '0;
      soak      <= '0;
      bad       <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      retry_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_ARM;
          addr      <= '0;
          bad       <= 1'b0;
          done      <= 1'b0;
          fail      <= 1'b0;
          fail_addr <= '0;
          retry_cnt <= '0;
        end
        S_ARM:  if (bus_rdy) state <= S_FIRE;
        S_FIRE: if (bus_rdy) begin
          state <= S_SOAK;
          soak  <= pulse_cycles;
        end
        S_SOAK: begin
          if (soak <= PULSE_W'(1)) state <= S_VCMD;
          else soak <= soak - PULSE_W'(1);
        end
        S_VCMD: if (bus_rdy) state <= S_RREQ;
        S_RREQ: if (bus_rdy) state <= S_RWAIT;
        S_RWAIT: if (bus_rvalid) begin
          if (bus_rdata == ERASED) begin
            if (addr == LAST_ADDR) state <= S_EXIT;
            else begin
              addr  <= addr + ADDR_W'(1);
              state <= S_VCMD;
            end
          end else if (retry_cnt == RETRY_TOP) begin
            bad       <= 1'b1;
            fail_addr <= addr;
            state     <= S_EXIT;
          end else begin
            retry_cnt <= retry_cnt + RETRY_W'(1);
            state     <= S_ARM;
          end
        end
        S_EXIT: if (bus_rdy) begin
          state <= S_IDLE;
          done  <= !bad;
          fail  <= bad;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign bus_wr = (state == S_ARM) || (state == S_FIRE) ||
                  (state == S_VCMD) || (state == S_EXIT);
  assign bus_rd = (state == S_RREQ);
  assign bus_addr = ((state == S_VCMD) || (state == S_RREQ)) ? addr : '0;

  always_comb begin
    case (state)
      S_ARM, S_FIRE: bus_wdata = CMD_ERASE;
      S_VCMD:        bus_wdata = CMD_VFY;
      default:       bus_wdata = CMD_READ;
    endcase
  end
endmodule

// File: rtl/erase_verify_seq_chk.sv
module erase_verify_seq_chk #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int PULSE_W   = 20,
  parameter int RETRY_W   = 10,
  parameter int MAX_RETRY = 1000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [PULSE_W-1:0] pulse_cycles,
  input logic               bus_rdy,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic [RETRY_W-1:0] retry_cnt
);
  localparam logic [DATA_W-1:0] C_ERASE = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0] C_VFY   = DATA_W'(8'hA0);

  logic               wr_acc, rd_acc, vfy_acc;
  logic               vfy_open, timing, seen_v;
  logic [PULSE_W:0]   gap;
  logic [PULSE_W-1:0] plat;
  logic [ADDR_W-1:0]  last_v;

  assign wr_acc  = bus_wr && bus_rdy;
  assign rd_acc  = bus_rd && bus_rdy;
  assign vfy_acc = wr_acc && (bus_wdata == C_VFY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfy_open <= 1'b0;
      timing   <= 1'b0;
      seen_v   <= 1'b0;
      gap      <= '0;
      plat     <= '0;
      last_v   <= '0;
    end else begin
      if (start && !busy) seen_v <= 1'b0;
      if (vfy_acc) begin
        vfy_open <= 1'b1;
        seen_v   <= 1'b1;
        last_v   <= bus_addr;
      end else if (rd_acc) vfy_open <= 1'b0;
      if (wr_acc && bus_wdata == C_ERASE) begin
        timing <= 1'b1;
        gap    <= '0;
        plat   <= pulse_cycles;
      end else begin
        if (wr_acc) timing <= 1'b0;
        if (gap != {(PULSE_W+1){1'b1}}) gap <= gap + 1'b1;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_wr && !bus_rd));
  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && bus_wr && bus_wdata == C_ERASE));
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rdy) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_rdy) |=> (bus_rd && $stable(bus_addr)));
  // R4
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_acc && timing) |-> (gap >= {1'b0, plat}));
  // R5
  read_after_vfy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (vfy_open && bus_addr == last_v));
  // R7
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_acc && seen_v) |-> (bus_addr >= last_v));
  // R10
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= RETRY_W'(MAX_RETRY));
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

bind erase_verify_seq erase_verify_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_W(PULSE_W),
  .RETRY_W(RETRY_W), .MAX_RETRY(MAX_RETRY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .pulse_cycles(pulse_cycles),
  .bus_rdy(bus_rdy), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy(busy), .done(done), .fail(fail),
  .retry_cnt(retry_cnt)
);

// File: tb/erase_verify_seq_tb.sv
module erase_verify_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int N  = 1 << AW;
  localparam int MR = 3;
  localparam int PW = 8;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [PW-1:0] pulse_cycles = '0;
  logic          bus_rdy = 1'b0;
  logic          bus_wr, bus_rd, busy, done, fail;
  logic [AW-1:0] bus_addr, fail_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = '0;
  logic          bus_rvalid = 1'b0;
  logic [RW-1:0] retry_cnt;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_verify_seq #(.ADDR_W(AW), .DATA_W(8), .PULSE_W(PW), .RETRY_W(RW), .MAX_RETRY(MR)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pulse_cycles(pulse_cycles),
    .bus_rdy(bus_rdy), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .retry_cnt(retry_cnt));

  // behavioural device: byte a reads FFh once need[a] erases have been done
  int need [N];
  int cyc = 0, exec_cyc = 0;
  int n_erase = 0, n_verify = 0, n_reads = 0, n_exit = 0, proto_err = 0, gap_err = 0;
  bit half = 0, erasing = 0, vlive = 0, d1_v = 0;
  logic [AW-1:0] vaddr = '0;
  logic [7:0] last_cmd = 8'hFF, d1_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_rvalid <= d1_v;
    bus_rdata  <= d1_data;
    d1_v <= 1'b0;
    if (start && !busy) begin
      n_erase <= 0; n_verify <= 0; n_reads <= 0; n_exit <= 0;
      proto_err <= 0; gap_err <= 0; half <= 0; erasing <= 0; vlive <= 0;
    end else begin
      if (bus_wr && bus_rdy) begin
        last_cmd <= bus_wdata;
        if (bus_wdata == 8'h20) begin
          if (half) begin
            half <= 0; erasing <= 1; n_erase <= n_erase + 1; exec_cyc <= cyc;
          end else half <= 1;
        end else begin
          if (half) proto_err <= proto_err + 1;
          half <= 0;
          if (bus_wdata == 8'hA0) begin
            if (erasing && (cyc - exec_cyc) < int'(pulse_cycles)) gap_err <= gap_err + 1;
            erasing <= 0; vlive <= 1; vaddr <= bus_addr; n_verify <= n_verify + 1;
          end else if (bus_wdata == 8'h00) begin
            erasing <= 0; vlive <= 0; n_exit <= n_exit + 1;
          end else proto_err <= proto_err + 1;
        end
      end
      if (bus_rd && bus_rdy) begin
        if (!vlive || bus_addr != vaddr) proto_err <= proto_err + 1;
        vlive <= 0;
        n_reads <= n_reads + 1;
        d1_v <= 1'b1;
        d1_data <= (need[bus_addr] <= n_erase) ? 8'hFF : {1'b0, 3'b101, bus_addr};
      end
    end
  end

  initial begin : rdy_drv
    logic [7:0] lf;
    lf = 8'hA5;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      bus_rdy = lf[0] | lf[2];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int need_fn(input int pat, input int a);
    case (pat)
      0: return 1;
      1: return 0;
      2: return (a == N-1) ? 3 : 1;
      3: return a % 3 + 1;
      4: return (a == 5) ? 6 : 1;
      5: return (a == 0) ? MR + 1 : 1;
      6: return a >> 1;
      default: return (a == 0) ? MR + 2 : 1;
    endcase
  endfunction

  task automatic run_case(input int pat, input int pw, input bit restart);
    int e, ret, ver, fa, w;
    bit ok;
    for (int a = 0; a < N; a++) need[a] = need_fn(pat, a);
    e = 1; ret = 0; ver = 0; ok = 1; fa = 0;
    for (int a = 0; a < N && ok; a++) begin
      for (int t = 0; t < 64; t++) begin
        ver++;
        if (need[a] <= e) break;
        if (ret == MR) begin ok = 0; fa = a; break; end
        ret++; e++;
      end
    end
    pulse_cycles = PW'(pw);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done && !fail, "R9 flags cleared by start", {busy, done, fail}, 4);
    if (restart) begin
      repeat (30) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    w = 0;
    while (!(done || fail) && w < 20000) begin @(negedge clk); w++; end
    chk(w < 20000, "R6 run completes", w, 0);
    chk(done == ok, "R6/R9 done", done, ok);
    chk(fail == !ok, "R8 fail", fail, !ok);
    chk(!busy, "R9 idle after exit", busy, 0);
    chk(int'(retry_cnt) == ret, "R10 retry_cnt", retry_cnt, ret);
    chk(n_erase == ret + 1, "R7/R10 erase count", n_erase, ret + 1);
    chk(n_verify == ver, "R7 verify count (resume point)", n_verify, ver);
    chk(n_reads == ver, "R5 read count", n_reads, ver);
    chk(proto_err == 0, "R2/R5 bus order", proto_err, 0);
    chk(gap_err == 0, "R4 pulse gap", gap_err, 0);
    chk(n_exit == 1 && last_cmd == 8'h00, "R9 exit write", n_exit, 1);
    if (!ok) chk(int'(fail_addr) == fa, "R8 fail_addr", fail_addr, fa);
    repeat (5) @(negedge clk);
    chk(done == ok && fail == !ok && !bus_wr && !bus_rd, "R9 sticky flags", {done, fail}, {ok, !ok});
  endtask

  initial begin
    for (int a = 0; a < N; a++) need[a] = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_wr && !bus_rd && !done && !fail && retry_cnt == 0,
        "R1 reset state", {busy, bus_wr, bus_rd, done, fail}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_wr && !bus_rd, "R1 idle after reset", {busy, bus_wr, bus_rd}, 0);
    for (int p = 0; p < 8; p++) begin
      run_case(p, (p % 4 == 0) ? 0 : (p % 4 == 1) ? 1 : (p % 4 == 2) ? 5 : 12, p == 3);
    end
    run_case(2, 20, 1'b1);
    run_case(6, 3, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule